// File: doc/BRIEF.md
# Serially Loaded Bank Window Mapper

This block gives a coprocessor with a 16-bit address space a 32 KiB window into a 24-bit host address space. When the coprocessor accesses an address inside the window page, the block turns it into a host bus request. The host address is the current bank base with the window offset placed in its low 15 bits. Direction and write data pass straight through. The coprocessor side stays stalled until the host raises its ready signal. For reads, the host's data is returned to the coprocessor in that same cycle.

The bank base is not loaded in one parallel write. Each write to a single one-byte bank register shifts the stored base one place toward bit 15 and inserts bit 0 of the written byte at bit 23. Bits 14 to 0 of the base are always zero. Nine successive writes therefore set all nine base bits, with the first bit written ending up at bit 15. Reads of the bank register return all ones and leave the base unchanged. Any coprocessor access that hits neither the window nor the bank register completes at once with no host activity.

Top module: `bank_window_mapper`

## Requirements
- R1: After reset the bank base is zero, so the first window access drives a host address equal to the window offset; with no request, cp_ack and host_req are low.
- R2: A coprocessor write to the bank register (address 0x6000) completes in the cycle it is presented. From the next cycle on, base bit 23 equals bit 0 of the written byte, each base bit 22..15 takes the old value of the bit above it, and base bits 14..0 stay zero.
- R3: After nine consecutive bank writes carrying bits b0..b8 (b0 first), host address bit 15+i equals bi for every i, and host address bits 14..0 equal the window offset.
- R4: A window access (coprocessor address bit 15 set) drives host_addr = {base[23:15], cp_addr[14:0]}, host_we = cp_we and host_wdata = cp_wdata.
- R5: While a window access is pending and host_ready is low, host_req is high and cp_ack is low; cp_ack rises in the first cycle that host_ready is high, including the cycle the request is raised.
- R6: On the completing cycle of a window read, cp_rdata equals host_rdata.
- R7: A read of the bank register completes at once, returns 0xFF, raises no host request and leaves the base unchanged.
- R8: Bits 7..1 of a bank-register write are ignored; only bit 0 enters the base.
- R9: An access to an address outside the window other than the bank register completes in the same cycle, raises no host request, returns 0xFF on a read and does not change the base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cp_req | input | 1 | Coprocessor access request, held until cp_ack |
| cp_we | input | 1 | Coprocessor write (1) or read (0) |
| cp_addr | input | 16 | Coprocessor address |
| cp_wdata | input | 8 | Coprocessor write data |
| cp_ack | output | 1 | Access completes this cycle |
| cp_rdata | output | 8 | Read data to the coprocessor |
| host_req | output | 1 | Host bus request for a window access |
| host_we | output | 1 | Host access direction, 1 for write |
| host_addr | output | 24 | Translated host address |
| host_wdata | output | 8 | Host write data |
| host_ready | input | 1 | Host completes the pending access |
| host_rdata | input | 8 | Host read data |

## Verification
Two functions meet in the same cycle in this block. The first is a bank-register write and the window access issued right after it: the access must already use the shifted base one clock edge after the write. The bench provokes this by running bank writes and window accesses back to back with no idle cycle. The second is a request meeting host_ready in its very first cycle, which tests the zero-wait completion. Randomly mixed operations with random wait counts and data are judged against a base model kept in the bench, which checks every host address, the stall and the returned data.

// File: rtl/bwm_pkg.sv
package bwm_pkg;
   // Target of a coprocessor access
   typedef enum logic [1:0] {
      SEL_NONE   = 2'd0,
      SEL_WINDOW = 2'd1,
      SEL_BANK   = 2'd2
   } sel_e;
endpackage

// File: rtl/bwm_decode.sv
module bwm_decode
   import bwm_pkg::*;
#(
   parameter int unsigned CP_AW     = 16,
   parameter int unsigned WIN_AW    = 15,
   parameter int unsigned WIN_PAGE  = 1,
   parameter int unsigned BANK_ADDR = 'h6000
) (
   input  logic [CP_AW-1:0] cp_addr,
   output sel_e             sel
);
   localparam int unsigned PAGE_W = CP_AW - WIN_AW;

   generate
      if (PAGE_W == 0) begin : g_full_window
         // whole coprocessor space is the window; register unreachable
         assign sel = SEL_WINDOW;
      end else begin : g_paged
         logic page_hit;
         logic reg_hit;
         assign page_hit = (cp_addr[CP_AW-1:WIN_AW] == PAGE_W'(WIN_PAGE));
         assign reg_hit  = (cp_addr == CP_AW'(BANK_ADDR));
         always_comb begin
            if (page_hit)      sel = SEL_WINDOW;
            else if (reg_hit)  sel = SEL_BANK;
            else               sel = SEL_NONE;
         end
      end
   endgenerate
endmodule

// File: rtl/bwm_base_shifter.sv
module bwm_base_shifter #(
   parameter int unsigned BANK_BITS = 9
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 load,
   input  logic                 bit_in,
   output logic [BANK_BITS-1:0] base_q
);
   // One flop per kept base bit; the top one takes the new bit,
   // every other one takes its upper neighbour.
   genvar gi;
   generate
      for (gi = 0; gi < BANK_BITS; gi++) begin : g_bit
         logic nxt;
         if (gi == BANK_BITS - 1) begin : g_top
            assign nxt = bit_in;
         end else begin : g_inner
            assign nxt = base_q[gi+1];
         end
         always_ff @(posedge clk) begin
            if (!rst_n)    base_q[gi] <= 1'b0;
            else if (load) base_q[gi] <= nxt;
         end
      end
   endgenerate

   assert_reset_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (base_q == '0));

   assert_shift_down_R2: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (base_q[BANK_BITS-2:0] == $past(base_q[BANK_BITS-1:1])));

   assert_new_top_R2: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (base_q[BANK_BITS-1] == $past(bit_in)));

   assert_hold_base_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> (base_q == $past(base_q)));
endmodule

// File: rtl/bwm_host_port.sv
module bwm_host_port #(
   parameter int unsigned HOST_AW     = 24,
   parameter int unsigned WIN_AW      = 15,
   parameter int unsigned DW          = 8,
   parameter bit          ADD_COMPOSE = 1'b0
) (
   input  logic                        win_sel,
   input  logic                        cp_we,
   input  logic [WIN_AW-1:0]           offset,
   input  logic [DW-1:0]               cp_wdata,
   input  logic [HOST_AW-WIN_AW-1:0]   base,
   output logic                        host_req,
   output logic                        host_we,
   output logic [HOST_AW-1:0]          host_addr,
   output logic [DW-1:0]               host_wdata,
   input  logic                        host_ready,
   output logic                        win_done
);
   generate
      if (ADD_COMPOSE) begin : g_adder
         // full add of shifted base and offset; same result, longer path
         assign host_addr = {base, {WIN_AW{1'b0}}} + HOST_AW'(offset);
      end else begin : g_concat
         assign host_addr = {base, offset};
      end
   endgenerate

   assign host_req   = win_sel;
   assign host_we    = cp_we;
   assign host_wdata = cp_wdata;
   assign win_done   = win_sel & host_ready;
endmodule

// File: rtl/bank_window_mapper.sv
module bank_window_mapper
   import bwm_pkg::*;
#(
   parameter int unsigned CP_AW       = 16,
   parameter int unsigned HOST_AW     = 24,
   parameter int unsigned WIN_AW      = 15,
   parameter int unsigned DW          = 8,
   parameter int unsigned WIN_PAGE    = 1,
   parameter int unsigned BANK_ADDR   = 'h6000,
   parameter bit          ADD_COMPOSE = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cp_req,
   input  logic               cp_we,
   input  logic [CP_AW-1:0]   cp_addr,
   input  logic [DW-1:0]      cp_wdata,
   output logic               cp_ack,
   output logic [DW-1:0]      cp_rdata,
   output logic               host_req,
   output logic               host_we,
   output logic [HOST_AW-1:0] host_addr,
   output logic [DW-1:0]      host_wdata,
   input  logic               host_ready,
   input  logic [DW-1:0]      host_rdata
);
   localparam int unsigned BANK_BITS = HOST_AW - WIN_AW;
   localparam int unsigned PAGE_W    = CP_AW - WIN_AW;

   // elaboration-time parameter checks
   generate
      if (WIN_AW >= HOST_AW) begin : g_chk_host
         $error("window must be smaller than host space");
      end
      if (BANK_BITS < 2) begin : g_chk_bits
         $error("bank base needs at least two bits");
      end
      if (WIN_AW > CP_AW) begin : g_chk_cp
         $error("window exceeds coprocessor space");
      end
      if (DW < 1) begin : g_chk_dw
         $error("data width must be positive");
      end
      if (PAGE_W > 0) begin : g_chk_page
         if ((BANK_ADDR >> WIN_AW) == WIN_PAGE) begin : g_chk_overlap
            $error("bank register lies inside the window");
         end
      end
   endgenerate

   sel_e                 sel;
   logic                 win_sel;
   logic                 bank_load;
   logic                 win_done;
   logic [BANK_BITS-1:0] base_q;

   bwm_decode #(
      .CP_AW    (CP_AW),
      .WIN_AW   (WIN_AW),
      .WIN_PAGE (WIN_PAGE),
      .BANK_ADDR(BANK_ADDR)
   ) u_decode (
      .cp_addr(cp_addr),
      .sel    (sel)
   );

   assign win_sel   = cp_req & (sel == SEL_WINDOW);
   assign bank_load = cp_req & cp_we & (sel == SEL_BANK);

   bwm_base_shifter #(
      .BANK_BITS(BANK_BITS)
   ) u_base (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (bank_load),
      .bit_in(cp_wdata[0]),
      .base_q(base_q)
   );

   bwm_host_port #(
      .HOST_AW    (HOST_AW),
      .WIN_AW     (WIN_AW),
      .DW         (DW),
      .ADD_COMPOSE(ADD_COMPOSE)
   ) u_host (
      .win_sel   (win_sel),
      .cp_we     (cp_we),
      .offset    (cp_addr[WIN_AW-1:0]),
      .cp_wdata  (cp_wdata),
      .base      (base_q),
      .host_req  (host_req),
      .host_we   (host_we),
      .host_addr (host_addr),
      .host_wdata(host_wdata),
      .host_ready(host_ready),
      .win_done  (win_done)
   );

   // non-window targets finish at once; window waits for the host
   assign cp_ack   = cp_req & ((sel != SEL_WINDOW) | win_done);
   assign cp_rdata = (sel == SEL_WINDOW) ? host_rdata : {DW{1'b1}};

   assert_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cp_req && sel == SEL_WINDOW && !host_ready) |-> (host_req && !cp_ack));

   assert_ready_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (host_req && host_ready) |-> cp_ack);

   assert_read_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cp_ack && !cp_we && sel == SEL_WINDOW) |-> (cp_rdata == host_rdata));

   assert_reg_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cp_req && !cp_we && sel == SEL_BANK) |-> (cp_ack && !host_req && cp_rdata == {DW{1'b1}}));

   assert_unmapped_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cp_req && sel == SEL_NONE) |=> $stable(base_q));

   assert_addr_base_R4: assert property (@(posedge clk) disable iff (!rst_n)
      host_req |-> (host_addr[HOST_AW-1:WIN_AW] == base_q));
endmodule

// File: tb/bank_window_mapper_bench.sv
module bank_window_mapper_bench;
   localparam int CLK_PERIOD = 10;
   localparam logic [15:0] BANK_REG = 16'h6000;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        cp_req, cp_we;
   logic [15:0] cp_addr;
   logic [7:0]  cp_wdata;
   logic        cp_ack;
   logic [7:0]  cp_rdata;
   logic        host_req, host_we;
   logic [23:0] host_addr;
   logic [7:0]  host_wdata;
   logic        host_ready;
   logic [7:0]  host_rdata;

   int checks = 0;
   int errors = 0;
   logic [8:0] exp_base = 9'd0;

   always #(CLK_PERIOD/2) clk = ~clk;

   bank_window_mapper u_bank_window_mapper (
      .clk(clk), .rst_n(rst_n),
      .cp_req(cp_req), .cp_we(cp_we), .cp_addr(cp_addr), .cp_wdata(cp_wdata),
      .cp_ack(cp_ack), .cp_rdata(cp_rdata),
      .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
      .host_wdata(host_wdata), .host_ready(host_ready), .host_rdata(host_rdata)
   );

   function automatic logic [23:0] exp_addr(input logic [8:0] b, input logic [14:0] off);
      return {b, off};
   endfunction

   function automatic logic [8:0] next_base(input logic [8:0] b, input logic [7:0] d);
      return {d[0], b[8:1]};
   endfunction

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // all tasks start at a negedge and end at a negedge
   task automatic win_access(input bit we, input logic [14:0] off, input logic [7:0] wd,
                             input int waits, input logic [7:0] hrd, input string tag);
      cp_req = 1'b1; cp_we = we; cp_addr = {1'b1, off}; cp_wdata = wd;
      host_ready = 1'b0; host_rdata = ~hrd;
      for (int i = 0; i < waits; i++) begin
         #1;
         chk("R5", "host_req while waiting", host_req, 1);
         chk("R5", "cp_ack while waiting", cp_ack, 0);
         chk(tag, "host_addr while waiting", host_addr, exp_addr(exp_base, off));
         @(negedge clk);
      end
      host_ready = 1'b1; host_rdata = hrd;
      #1;
      chk("R5", "cp_ack on ready", cp_ack, 1);
      chk(tag, "host_addr", host_addr, exp_addr(exp_base, off));
      chk("R4", "host_we", host_we, we);
      if (we) chk("R4", "host_wdata", host_wdata, wd);
      else    chk("R6", "cp_rdata", cp_rdata, hrd);
      @(negedge clk);
      cp_req = 1'b0; host_ready = 1'b0;
   endtask

   task automatic bank_write(input logic [7:0] d);
      cp_req = 1'b1; cp_we = 1'b1; cp_addr = BANK_REG; cp_wdata = d;
      #1;
      chk("R2", "bank write ack", cp_ack, 1);
      chk("R2", "bank write host_req", host_req, 0);
      @(negedge clk);
      exp_base = next_base(exp_base, d);
      cp_req = 1'b0;
   endtask

   task automatic bank_read();
      cp_req = 1'b1; cp_we = 1'b0; cp_addr = BANK_REG; cp_wdata = 8'h00;
      #1;
      chk("R7", "bank read ack", cp_ack, 1);
      chk("R7", "bank read data", cp_rdata, 8'hFF);
      chk("R7", "bank read host_req", host_req, 0);
      @(negedge clk);
      cp_req = 1'b0;
   endtask

   task automatic other_access(input bit we, input logic [14:0] a, input logic [7:0] wd);
      cp_req = 1'b1; cp_we = we; cp_addr = {1'b0, a}; cp_wdata = wd;
      #1;
      chk("R9", "unmapped ack", cp_ack, 1);
      chk("R9", "unmapped host_req", host_req, 0);
      if (!we) chk("R9", "unmapped read data", cp_rdata, 8'hFF);
      @(negedge clk);
      cp_req = 1'b0;
   endtask

   task automatic probe_bits(input logic [8:0] b);
      cp_req = 1'b1; cp_we = 1'b0; cp_addr = 16'h8000 | 16'h0ABC; host_ready = 1'b1;
      #1;
      for (int i = 0; i < 9; i++)
         chk("R3", $sformatf("host_addr bit %0d", 15 + i), host_addr[15+i], b[i]);
      chk("R3", "host_addr offset bits", host_addr[14:0], 15'h0ABC);
      @(negedge clk);
      cp_req = 1'b0; host_ready = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [8:0] pat;
      void'($urandom(32'h5EED_0042));
      rst_n = 1'b0; cp_req = 1'b0; cp_we = 1'b0; cp_addr = '0; cp_wdata = '0;
      host_ready = 1'b0; host_rdata = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      chk("R1", "idle cp_ack", cp_ack, 0);
      chk("R1", "idle host_req", host_req, 0);
      @(negedge clk);

      // R1: base zero after reset, zero-wait read
      win_access(1'b0, 15'h1234, 8'h00, 0, 8'h5A, "R1");

      // R3: nine writes, back to back, then immediate probe
      pat = 9'b1_0110_1001;
      for (int i = 0; i < 9; i++) bank_write({7'h55, pat[i]});
      probe_bits(pat);

      // R2: single shift, back to back with a waiting window write
      bank_write(8'h01);
      win_access(1'b1, 15'h7FFF, 8'hC3, 3, 8'h00, "R2");

      // R8: upper data bits ignored
      bank_write(8'hFE);
      win_access(1'b0, 15'h0001, 8'h00, 1, 8'hA5, "R8");
      bank_write(8'h01);
      win_access(1'b0, 15'h0002, 8'h00, 0, 8'h3C, "R8");

      // R7: register read leaves base alone
      bank_read();
      win_access(1'b0, 15'h4000, 8'h00, 2, 8'h77, "R7");

      // R9: unmapped accesses leave base alone
      other_access(1'b1, 15'h1000, 8'hFF);
      other_access(1'b0, 15'h6001, 8'h00);
      win_access(1'b0, 15'h0000, 8'h00, 0, 8'h11, "R9");

      // random mix, R4
      for (int n = 0; n < 400; n++) begin
         int op;
         op = int'($urandom_range(0, 4));
         case (op)
            0: bank_write(8'($urandom));
            1: win_access(1'b0, 15'($urandom), 8'h00, int'($urandom_range(0, 4)),
                          8'($urandom), "R4");
            2: win_access(1'b1, 15'($urandom), 8'($urandom), int'($urandom_range(0, 4)),
                          8'h00, "R4");
            3: bank_read();
            default: begin
               logic [14:0] a;
               a = 15'($urandom);
               if ({1'b0, a} == BANK_REG) a = 15'h0100;
               other_access(1'($urandom), a, 8'($urandom));
            end
         endcase
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule